// File: doc/BRIEF.md
# Watchdog and Back-off Recovery Supervisor

This block supervises the active processor of a duplex system whose second processor waits as a cold spare. It joins two recovery paths. The first handles parity errors. On a parity error the processor is told to wait for a programmable number of cycles. It is then asked to run its last instruction again. A parity error during that retry locks the wait on for good.

The second path is a watchdog that the periodic interrupt service must kick. If the watchdog runs out once, a one-cycle interrupt starts a rollback to the last checkpoint. If it runs out a second time with no kick in between, the main processor is halted and the spare is started. Both outputs then stay set until reset.

Both the wait length and the watchdog timeout are sampled live from input ports. The processors, the memory and the checkpoint store sit outside the block.

Top module: `recovery_supervisor`

## Requirements
- R1: While and just after rst_ni is low, backoff_o, reexec_o, ckpt_irq_o, halt_o and spare_start_o are all 0.
- R2: A parity error sampled with the block idle (backoff_o, reexec_o and halt_o all 0) raises backoff_o at the next edge. backoff_o then stays high for exactly backoff_len_i cycles, where a length of 0 acts as 1. Parity errors that arrive while backoff_o is high are ignored.
- R3: The cycle after backoff_o falls, reexec_o is high. It stays high until retry_done_i is sampled high, and is low from the following cycle on.
- R4: A parity error sampled while reexec_o is high drops reexec_o and raises backoff_o for good, until reset.
- R5: A watchdog kick restarts the timeout. If the gap between kicks is shorter than wd_limit_i cycles, no overflow ever happens. A limit of 0 acts as 1.
- R6: After wd_limit_i cycles with no kick, since reset, since a kick or since the last overflow, the watchdog overflows. A first overflow gives a ckpt_irq_o pulse exactly one cycle long, and the count starts again.
- R7: A second overflow with no kick since the first raises halt_o and spare_start_o. It gives no ckpt_irq_o pulse, and both outputs stay high until reset.
- R8: A kick after a first overflow clears the pending escalation. The next overflow gives a ckpt_irq_o pulse again, not a halt.
- R9: A parity error sampled while the back-off is locked, or while halt_o is high, changes no output.
- R10: Once halted, the watchdog stops, and ckpt_irq_o stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| parity_err_i | input | 1 | Parity error seen by the processor |
| wd_kick_i | input | 1 | Kick from the periodic interrupt service |
| retry_done_i | input | 1 | Processor has finished re-executing |
| backoff_len_i | input | BO_W | Back-off length in cycles |
| wd_limit_i | input | WD_W | Watchdog timeout in cycles |
| backoff_o | output | 1 | Processor wait |
| reexec_o | output | 1 | Re-execute the last instruction |
| ckpt_irq_o | output | 1 | Checkpoint rollback interrupt pulse |
| halt_o | output | 1 | Stop the main processor (sticky) |
| spare_start_o | output | 1 | Start the spare processor (sticky) |

## Verification
The properties take for granted that backoff_len_i and wd_limit_i are held steady while a back-off or a timeout is under way. They also take for granted that retry_done_i matters only while reexec_o is high. The stimulus sets both configuration values only at reset, or between directed phases. It draws parity errors, kicks and retry completions at random rates per episode, so that back-off, lock, rollback and halt all occur. Kick rates are chosen so that some episodes overflow and others do not.

// File: rtl/recov_sup_pkg.sv
package recov_sup_pkg;
  typedef enum logic [1:0] {
    BO_IDLE  = 2'd0,
    BO_HOLD  = 2'd1,
    BO_RETRY = 2'd2,
    BO_LOCK  = 2'd3
  } bo_state_e;
endpackage

// File: rtl/backoff_gen.sv
module backoff_gen
  import recov_sup_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             parity_i,
  input  logic             retry_done_i,
  input  logic             freeze_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             backoff_o,
  output logic             reexec_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bo_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             par_eff;
  logic [CNT_W-1:0] len_eff;

  // halted processor: parity no longer acted on
  assign par_eff = parity_i & ~freeze_i;
  assign len_eff = (len_i == '0) ? ONE : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BO_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        BO_IDLE: if (par_eff) begin
          state_q <= BO_HOLD;
          cnt_q   <= len_eff;
        end
        BO_HOLD: begin
          if (cnt_q <= ONE) state_q <= BO_RETRY;
          else              cnt_q   <= cnt_q - ONE;
        end
        BO_RETRY: begin
          if (par_eff)           state_q <= BO_LOCK;
          else if (retry_done_i) state_q <= BO_IDLE;
        end
        default: state_q <= BO_LOCK;
      endcase
    end
  end

  assign backoff_o = (state_q == BO_HOLD) || (state_q == BO_LOCK);
  assign reexec_o  = (state_q == BO_RETRY);
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             irq_o,
  output logic             halt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_eff;
  logic             strike_q, irq_q, halt_q;

  assign lim_eff = (limit_i == '0) ? ONE : limit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strike_q <= 1'b0;
      irq_q    <= 1'b0;
      halt_q   <= 1'b0;
    end else if (halt_q) begin
      irq_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q    <= '0;
      strike_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (cnt_q >= lim_eff - ONE) begin
      // overflow: first one rolls back, a repeat escalates
      cnt_q    <= '0;
      irq_q    <= ~strike_q;
      halt_q   <= strike_q;
      strike_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + ONE;
      irq_q <= 1'b0;
    end
  end

  assign irq_o  = irq_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/recovery_supervisor.sv
module recovery_supervisor #(
  parameter int unsigned BO_W = 8,
  parameter int unsigned WD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            parity_err_i,
  input  logic            wd_kick_i,
  input  logic            retry_done_i,
  input  logic [BO_W-1:0] backoff_len_i,
  input  logic [WD_W-1:0] wd_limit_i,
  output logic            backoff_o,
  output logic            reexec_o,
  output logic            ckpt_irq_o,
  output logic            halt_o,
  output logic            spare_start_o
);
  logic halted;

  backoff_gen #(.CNT_W(BO_W)) u_backoff (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .parity_i     (parity_err_i),
    .retry_done_i (retry_done_i),
    .freeze_i     (halted),
    .len_i        (backoff_len_i),
    .backoff_o    (backoff_o),
    .reexec_o     (reexec_o)
  );

  wdog_escalator #(.CNT_W(WD_W)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_i  (wd_kick_i),
    .limit_i (wd_limit_i),
    .irq_o   (ckpt_irq_o),
    .halt_o  (halted)
  );

  assign halt_o        = halted;
  assign spare_start_o = halted;
endmodule

// File: rtl/recov_sup_chk.sv
module recov_sup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic parity_err_i,
  input logic retry_done_i,
  input logic backoff_o,
  input logic reexec_o,
  input logic ckpt_irq_o,
  input logic halt_o,
  input logic spare_start_o
);
  // R2
  backoff_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_i && !backoff_o && !reexec_o && !halt_o |=> backoff_o);

  // R3
  reexec_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(backoff_o) |-> reexec_o);

  // R3
  reexec_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(backoff_o && reexec_o));

  // R4
  retry_fail_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reexec_o && parity_err_i && !halt_o |=> backoff_o && !reexec_o);

  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_irq_o |=> !ckpt_irq_o);

  // R7
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && spare_start_o);

  // R10
  halted_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> !ckpt_irq_o);
endmodule

bind recovery_supervisor recov_sup_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .parity_err_i  (parity_err_i),
  .retry_done_i  (retry_done_i),
  .backoff_o     (backoff_o),
  .reexec_o      (reexec_o),
  .ckpt_irq_o    (ckpt_irq_o),
  .halt_o        (halt_o),
  .spare_start_o (spare_start_o)
);

// File: tb/recovery_supervisor_tb_top.sv
module recovery_supervisor_tb_top;
  localparam int BO_W = 8;
  localparam int WD_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic parity_err_i = 1'b0, wd_kick_i = 1'b0, retry_done_i = 1'b0;
  logic [BO_W-1:0] backoff_len_i = '0;
  logic [WD_W-1:0] wd_limit_i = '0;
  logic backoff_o, reexec_o, ckpt_irq_o, halt_o, spare_start_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_bs, m_bc, m_wc;
  bit m_strike, m_halt, m_irq;

  always #5 clk = ~clk;

  recovery_supervisor #(.BO_W(BO_W), .WD_W(WD_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .parity_err_i(parity_err_i),
    .wd_kick_i(wd_kick_i), .retry_done_i(retry_done_i),
    .backoff_len_i(backoff_len_i), .wd_limit_i(wd_limit_i),
    .backoff_o(backoff_o), .reexec_o(reexec_o), .ckpt_irq_o(ckpt_irq_o),
    .halt_o(halt_o), .spare_start_o(spare_start_o)
  );

  function automatic bit exp_backoff();
    return (m_bs == 1) || (m_bs == 3);
  endfunction

  function automatic bit exp_reexec();
    return m_bs == 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_bs = 0; m_bc = 0; m_wc = 0; m_strike = 0; m_halt = 0; m_irq = 0;
  endtask

  task automatic model_step();
    bit par;
    int lim;
    par = parity_err_i && !m_halt;
    case (m_bs)
      0: if (par) begin m_bs = 1; m_bc = (backoff_len_i == 0) ? 1 : int'(backoff_len_i); end
      1: if (m_bc <= 1) m_bs = 2; else m_bc--;
      2: if (par) m_bs = 3; else if (retry_done_i) m_bs = 0;
      default: m_bs = 3;
    endcase
    lim = (wd_limit_i == 0) ? 1 : int'(wd_limit_i);
    if (m_halt) m_irq = 0;
    else if (wd_kick_i) begin m_wc = 0; m_strike = 0; m_irq = 0; end
    else if (m_wc >= lim - 1) begin
      m_wc = 0; m_irq = !m_strike;
      if (m_strike) m_halt = 1;
      m_strike = 1;
    end else begin m_wc++; m_irq = 0; end
  endtask

  task automatic compare();
    check(backoff_o == exp_backoff(), "R2 backoff_o", backoff_o, exp_backoff());
    check(reexec_o == exp_reexec(), "R3 reexec_o", reexec_o, exp_reexec());
    check(ckpt_irq_o == m_irq, "R6 ckpt_irq_o", ckpt_irq_o, m_irq);
    check(halt_o == m_halt, "R7 halt_o", halt_o, m_halt);
    check(spare_start_o == m_halt, "R7 spare_start_o", spare_start_o, m_halt);
  endtask

  // one clock: model follows the inputs at the edge, outputs checked at negedge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    parity_err_i = 0; wd_kick_i = 0; retry_done_i = 0;
    rst_ni = 0;
    model_reset();
    @(negedge clk);
    // R1
    check(!backoff_o && !reexec_o && !ckpt_irq_o && !halt_o && !spare_start_o,
          "R1 reset outputs", {backoff_o, reexec_o, ckpt_irq_o, halt_o, spare_start_o}, 0);
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1_800_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    @(negedge clk);

    // R2 R3: back-off of 3 then retry
    backoff_len_i = 8'd3; wd_limit_i = 16'd200;
    do_reset();
    wd_kick_i = 1;
    parity_err_i = 1; tick(); parity_err_i = 0;
    n = 0;
    while (backoff_o && n < 100) begin n++; tick(); end
    check(n == 3, "R2 backoff length", n, 3);
    tick(); tick();
    check(reexec_o == 1, "R3 reexec held", reexec_o, 1);
    retry_done_i = 1; tick(); retry_done_i = 0;
    check(reexec_o == 0, "R3 reexec cleared", reexec_o, 0);

    // R2 zero length acts as one; R4 retry failure locks
    backoff_len_i = 8'd0;
    parity_err_i = 1; tick(); parity_err_i = 0;
    check(backoff_o == 1, "R2 len0 backoff", backoff_o, 1);
    tick();
    check(reexec_o == 1 && backoff_o == 0, "R2 len0 one cycle", reexec_o, 1);
    parity_err_i = 1; tick(); parity_err_i = 0;
    for (int i = 0; i < 20; i++) tick();
    check(backoff_o == 1 && reexec_o == 0, "R4 permanent backoff", backoff_o, 1);
    // R9 parity while locked
    parity_err_i = 1; tick(); tick(); parity_err_i = 0;
    check(backoff_o == 1 && reexec_o == 0, "R9 locked ignores parity", reexec_o, 0);

    // R6 R8 R7 R10 watchdog escalation, limit 5
    wd_kick_i = 0; wd_limit_i = 16'd5;
    do_reset();
    n = 0;
    while (!ckpt_irq_o && n < 100) begin n++; tick(); end
    check(n == 5, "R6 first overflow", n, 5);
    tick();
    check(ckpt_irq_o == 0, "R6 pulse width", ckpt_irq_o, 0);
    wd_kick_i = 1; tick(); wd_kick_i = 0;
    n = 0;
    while (!ckpt_irq_o && !halt_o && n < 100) begin n++; tick(); end
    check(n == 5 && ckpt_irq_o && !halt_o, "R8 kick clears escalation", n, 5);
    n = 0;
    while (!halt_o && n < 100) begin n++; tick(); end
    check(n == 5 && spare_start_o, "R7 second overflow halts", n, 5);
    n = 0;
    for (int i = 0; i < 30; i++) begin tick(); n += ckpt_irq_o; end
    check(n == 0 && halt_o, "R10 halted no irq", n, 0);
    parity_err_i = 1; tick(); tick(); parity_err_i = 0;
    check(backoff_o == 0 && reexec_o == 0, "R9 halted ignores parity", backoff_o, 0);

    // R5 kicks every 4 cycles, limit 5
    do_reset();
    n = 0;
    for (int i = 0; i < 100; i++) begin
      wd_kick_i = (i % 4 == 3);
      tick();
      n += ckpt_irq_o + halt_o;
    end
    wd_kick_i = 0;
    check(n == 0, "R5 kicked watchdog silent", n, 0);

    // random episodes
    for (int ep = 0; ep < 24; ep++) begin
      int kp, pp, dp;
      backoff_len_i = BO_W'($urandom_range(0, 12));
      wd_limit_i = WD_W'($urandom_range(0, 40));
      kp = $urandom_range(1, 40);
      pp = $urandom_range(1, 15);
      dp = $urandom_range(5, 60);
      do_reset();
      for (int c = 0; c < 600; c++) begin
        wd_kick_i    = ($urandom_range(0, 99) < kp);
        parity_err_i = ($urandom_range(0, 99) < pp);
        retry_done_i = ($urandom_range(0, 99) < dp);
        tick();
      end
    end
    parity_err_i = 0; wd_kick_i = 0; retry_done_i = 0;

    done = 1;
    summary();
    $finish;
  end
endmodule